// File: doc/BRIEF.md
# Multiplexed Digit Scan and Strobe Generator

This block sequences the five digit-select lines of a multiplexed BCD readout and produces the active-low transfer strobes that tell downstream logic when each digit's data is valid. A one-cycle measurement-done pulse starts a strobed pass. The pass walks the digits from the most significant (D5) down to the least significant (D1) and drops the strobe once in the middle of each digit. The first digit period of the pass is one count longer than the rest. After the strobed pass the lines keep cycling without strobes so that a display stays refreshed. If the result that was latched with the measurement-done pulse was out of range, all lines go dark after the strobed pass instead.

A 3-bit digit index is driven alongside the one-hot lines so that an external multiplexer can pick the matching BCD nibble. The strobe is half a clock wide. It is formed by qualifying a registered enable with the low phase of the clock. The sequencer has three states. SCAN_IDLE drives no digit. SCAN_STROBED is the first pass, with strobes. SCAN_REFRESH is the repeating pass without strobes. The transitions are:
- reset to SCAN_IDLE;
- a measurement-done pulse from any state to SCAN_STROBED;
- from SCAN_STROBED at the end of D1, to SCAN_REFRESH if the latched overrange flag is clear, or to SCAN_IDLE if it is set;
- from SCAN_REFRESH at the end of D1, back to SCAN_REFRESH at D5.

Top module: `digit_scan_strobe`

## Requirements
- R1: After reset all digit lines are low, the digit index is 0 and the strobe is high, and this holds until a measurement-done pulse is sampled.
- R2: In the cycle after a measurement-done pulse is sampled, D5 (digit_en bit 4, index 4) goes high, and it stays high for 201 cycles.
- R3: After D5 the lines D4, D3, D2 and D1 (bits 3 to 0, index 3 to 0) each go high in that order for 200 cycles. A line always hands over to the next lower bit, and D1 hands over to D5.
- R4: At most one digit line is high at any time. While a line is high the index equals its bit position. While no line is high the index is 0.
- R5: The strobe goes low only during the low phase of the clock. In the strobed pass it goes low in the 101st cycle of each digit period: for D5 that is 101 cycles after the measurement-done pulse, and for D4 to D1 it is 100 cycles after the digit goes high.
- R6: Each measurement produces exactly five strobe pulses, one per digit, and none follows until the next measurement-done pulse.
- R7: When the latched overrange flag is clear, after D1 of the strobed pass the lines keep cycling D5, D4, D3, D2, D1 for 200 cycles each with the strobe held high.
- R8: When over_range was high with the measurement-done pulse, all lines go low after D1 of the strobed pass and stay low until the next measurement-done pulse.
- R9: A measurement-done pulse that arrives during scanning restarts the sequence at a 201-cycle D5 period, with the strobes armed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its low phase also forms the strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_done | input | 1 | One-cycle pulse marking the end of a measurement |
| over_range | input | 1 | Overrange flag, sampled together with meas_done |
| digit_en | output | 5 | One-hot digit lines; bit 4 is D5, bit 0 is D1 |
| digit_idx | output | 3 | Index of the active digit (4 for D5 down to 0 for D1) |
| strobe_n | output | 1 | Active-low half-clock transfer strobe |

## Verification
Assertions check on every cycle that the lines are one-hot or idle, that the index agrees with the active line, and that D5 follows a measurement-done pulse. They also check that each hand-over goes to the next lower digit, that no digit period runs past 201 cycles, and that dark lines stay dark without a new pulse. Only the bench scenarios can show the following: the exact 201 and 200 cycle boundaries, the placement of each half-clock strobe in its low phase, the total of five strobes per measurement, the absence of strobes during refresh, blanking after overrange, and restart in the middle of a scan.

// File: rtl/digit_scan_pkg.sv
package digit_scan_pkg;

    typedef enum logic [1:0] {
        SCAN_IDLE    = 2'd0,
        SCAN_STROBED = 2'd1,
        SCAN_REFRESH = 2'd2
    } scan_state_e;

endpackage

// File: rtl/dsc_seq.sv
// Digit sequencer: state, digit index, per-digit cycle counter and the
// registered strobe enable for the strobed pass.
module dsc_seq
    import digit_scan_pkg::*;
#(
    parameter int NUM_DIGITS   = 5,
    parameter int DIGIT_COUNTS = 200,
    parameter int FIRST_EXTRA  = 1,
    parameter int STROBE_POS   = 100,
    localparam int IDX_W = $clog2(NUM_DIGITS),
    localparam int CNT_W = $clog2(DIGIT_COUNTS + FIRST_EXTRA)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_done,
    input  logic             over_range,
    output scan_state_e      state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             stb_en_o
);

    localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(NUM_DIGITS - 1);
    localparam logic [CNT_W-1:0] LAST_LONG = CNT_W'(DIGIT_COUNTS + FIRST_EXTRA - 1);
    localparam logic [CNT_W-1:0] LAST_STD  = CNT_W'(DIGIT_COUNTS - 1);
    localparam logic [CNT_W-1:0] STB_CNT   = CNT_W'(STROBE_POS);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovr_q, ovr_d;
    logic             stb_q;
    logic [CNT_W-1:0] last_cnt;

    // First digit of the strobed pass is the long one
    assign last_cnt = (state_q == SCAN_STROBED && idx_q == TOP_IDX) ? LAST_LONG : LAST_STD;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        ovr_d   = ovr_q;
        if (meas_done) begin
            state_d = SCAN_STROBED;
            idx_d   = TOP_IDX;
            cnt_d   = '0;
            ovr_d   = over_range;
        end else begin
            unique case (state_q)
                SCAN_IDLE: begin
                    idx_d = '0;
                end
                SCAN_STROBED, SCAN_REFRESH: begin
                    if (cnt_q == last_cnt) begin
                        cnt_d = '0;
                        if (idx_q == '0) begin
                            if (state_q == SCAN_STROBED && ovr_q) begin
                                state_d = SCAN_IDLE;
                                idx_d   = '0;
                            end else begin
                                state_d = SCAN_REFRESH;
                                idx_d   = TOP_IDX;
                            end
                        end else begin
                            idx_d = idx_q - 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = SCAN_IDLE;
                    idx_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
            ovr_q   <= ovr_d;
        end
    end

    // Output register: strobe enable valid for the whole centre cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= (state_d == SCAN_STROBED) && (cnt_d == STB_CNT);
        end
    end

    assign state_o  = state_q;
    assign idx_o    = idx_q;
    assign stb_en_o = stb_q;

endmodule

// File: rtl/dsc_digit_decode.sv
// One-hot digit line decode from the sequencer index.
module dsc_digit_decode #(
    parameter int NUM_DIGITS = 5,
    localparam int IDX_W = $clog2(NUM_DIGITS)
) (
    input  logic                  active,
    input  logic [IDX_W-1:0]      idx,
    output logic [NUM_DIGITS-1:0] en,
    output logic [IDX_W-1:0]      idx_out
);

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_line
        assign en[g] = active && (idx == IDX_W'(g));
    end

    assign idx_out = active ? idx : '0;

endmodule

// File: rtl/dsc_strobe_gate.sv
// Half-clock strobe: the registered enable only changes at the rising
// edge, so qualifying it with the low clock phase cannot glitch.
module dsc_strobe_gate (
    input  logic clk,
    input  logic en_q,
    output logic strobe_n
);

    assign strobe_n = ~(en_q & ~clk);

endmodule

// File: rtl/digit_scan_strobe.sv
module digit_scan_strobe
    import digit_scan_pkg::*;
#(
    parameter int NUM_DIGITS   = 5,
    parameter int DIGIT_COUNTS = 200,
    parameter int FIRST_EXTRA  = 1,
    parameter int STROBE_POS   = 100,
    localparam int IDX_W = $clog2(NUM_DIGITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  meas_done,
    input  logic                  over_range,
    output logic [NUM_DIGITS-1:0] digit_en,
    output logic [IDX_W-1:0]      digit_idx,
    output logic                  strobe_n
);

    scan_state_e      seq_state;
    logic [IDX_W-1:0] seq_idx;
    logic             stb_en;

    dsc_seq #(
        .NUM_DIGITS  (NUM_DIGITS),
        .DIGIT_COUNTS(DIGIT_COUNTS),
        .FIRST_EXTRA (FIRST_EXTRA),
        .STROBE_POS  (STROBE_POS)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_done (meas_done),
        .over_range(over_range),
        .state_o   (seq_state),
        .idx_o     (seq_idx),
        .stb_en_o  (stb_en)
    );

    dsc_digit_decode #(
        .NUM_DIGITS(NUM_DIGITS)
    ) dec_i (
        .active (seq_state != SCAN_IDLE),
        .idx    (seq_idx),
        .en     (digit_en),
        .idx_out(digit_idx)
    );

    dsc_strobe_gate gate_i (
        .clk     (clk),
        .en_q    (stb_en),
        .strobe_n(strobe_n)
    );

endmodule

// File: rtl/digit_scan_strobe_chk.sv
module digit_scan_strobe_chk #(
    parameter int NUM_DIGITS   = 5,
    parameter int DIGIT_COUNTS = 200,
    parameter int FIRST_EXTRA  = 1,
    localparam int IDX_W = $clog2(NUM_DIGITS),
    localparam int RUN_W = $clog2(DIGIT_COUNTS + FIRST_EXTRA + 2) + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  meas_done,
    input logic [NUM_DIGITS-1:0] digit_en,
    input logic [IDX_W-1:0]      digit_idx
);

    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DIGIT_COUNTS + FIRST_EXTRA - 1);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(DIGIT_COUNTS + FIRST_EXTRA + 1);

    logic [NUM_DIGITS-1:0] prev_en_q;
    logic                  restart_q;
    logic [RUN_W-1:0]      run_q;
    logic [RUN_W-1:0]      run_now;

    // Position of the current cycle within the current digit period
    assign run_now = (restart_q || digit_en != prev_en_q) ? '0 : run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_en_q <= '0;
            restart_q <= 1'b0;
            run_q     <= '0;
        end else begin
            prev_en_q <= digit_en;
            restart_q <= meas_done;
            run_q     <= (run_now >= RUN_SAT) ? RUN_SAT : run_now + 1'b1;
        end
    end

    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(digit_en));

    a_r4_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_en != '0) |-> (digit_en == (NUM_DIGITS'(1) << digit_idx)));

    a_r2_d5_first: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> (digit_en == (NUM_DIGITS'(1) << (NUM_DIGITS - 1))));

    a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_en != '0 && $past(digit_en) != '0 && digit_en != $past(digit_en)
         && !$past(meas_done))
        |-> (digit_en == {$past(digit_en[0]), $past(digit_en[NUM_DIGITS-1:1])}));

    a_r3_max_run: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_en != '0) |-> (run_now <= RUN_MAX));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_en == '0 && !meas_done) |=> (digit_en == '0));

endmodule

bind digit_scan_strobe digit_scan_strobe_chk #(
    .NUM_DIGITS  (NUM_DIGITS),
    .DIGIT_COUNTS(DIGIT_COUNTS),
    .FIRST_EXTRA (FIRST_EXTRA)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .meas_done(meas_done),
    .digit_en (digit_en),
    .digit_idx(digit_idx)
);

// File: tb/digit_scan_strobe_tb_top.sv
`timescale 1ns/1ps
module digit_scan_strobe_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       meas_done = 1'b0;
    logic       over_range = 1'b0;
    logic [4:0] digit_en;
    logic [2:0] digit_idx;
    logic       strobe_n;

    int n_tests = 0;
    int n_fail  = 0;
    int stb_edges = 0;
    int hi_phase_low = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    digit_scan_strobe dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_done (meas_done),
        .over_range(over_range),
        .digit_en  (digit_en),
        .digit_idx (digit_idx),
        .strobe_n  (strobe_n)
    );

    always @(negedge strobe_n) stb_edges++;

    // Main vectors: cycle offset after the sampled pulse, expected lines,
    // index and strobe-low flag in the low phase of that cycle.
    localparam int N_VEC = 20;
    localparam int VEC_J [N_VEC] = '{
        0, 100, 101, 200,          // R2 R5: long D5 and its strobe
        201, 301, 400,             // R3 R5: D4
        401, 501,                  // D3
        601, 701, 800,             // D2
        801, 901, 1000,            // D1
        1001, 1101, 1200, 1201,    // R7 R6: refresh, no strobe
        2001                       // R7: second refresh wraps to D5
    };
    localparam logic [4:0] VEC_EN [N_VEC] = '{
        5'b10000, 5'b10000, 5'b10000, 5'b10000,
        5'b01000, 5'b01000, 5'b01000,
        5'b00100, 5'b00100,
        5'b00010, 5'b00010, 5'b00010,
        5'b00001, 5'b00001, 5'b00001,
        5'b10000, 5'b10000, 5'b10000, 5'b01000,
        5'b10000
    };
    localparam int VEC_IDX [N_VEC] = '{
        4, 4, 4, 4, 3, 3, 3, 2, 2, 1, 1, 1, 0, 0, 0, 4, 4, 4, 3, 4
    };
    localparam bit VEC_STB [N_VEC] = '{
        1'b0, 1'b1, 1'b0, 1'b0,
        1'b0, 1'b1, 1'b0,
        1'b0, 1'b1,
        1'b0, 1'b1, 1'b0,
        1'b0, 1'b1, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0,
        1'b0
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse meas_done for one cycle; returns 1 ns after the sampling edge.
    task automatic start_meas(input logic ovr);
        @(negedge clk);
        meas_done  = 1'b1;
        over_range = ovr;
        @(posedge clk);
        #1;
        meas_done  = 1'b0;
        over_range = 1'b0;
    endtask

    // Advance one cycle from high-phase sample point to the next.
    task automatic step();
        #5;
    endtask

    initial begin
        #(100000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // ---------------- R1: reset state ----------------
        repeat (3) @(posedge clk);
        #1;
        check(digit_en == 5'b0, "R1 lines in reset", digit_en, 0);
        rst_n = 1'b1;
        repeat (50) @(posedge clk);
        #1;
        check(digit_en == 5'b0, "R1 lines idle after reset", digit_en, 0);
        check(digit_idx == 3'd0, "R1 index idle", digit_idx, 0);
        #2;
        check(strobe_n == 1'b1, "R1 strobe idle", strobe_n, 1);
        #3;

        // ---------------- Vector walk: R2 R3 R5 R6 R7 ----------------
        start_meas(1'b0);
        stb_edges = 0;
        hi_phase_low = 0;
        for (int j = 0; j <= 2001; j++) begin
            if (strobe_n == 1'b0) hi_phase_low++;
            for (int k = 0; k < N_VEC; k++) begin
                if (VEC_J[k] == j) begin
                    check(digit_en == VEC_EN[k], "R2 R3 R7 vector lines", digit_en, VEC_EN[k]);
                    check(int'(digit_idx) == VEC_IDX[k], "R4 vector index", digit_idx, VEC_IDX[k]);
                end
            end
            #2;
            for (int k = 0; k < N_VEC; k++) begin
                if (VEC_J[k] == j) begin
                    check(strobe_n == !VEC_STB[k], "R5 vector strobe", strobe_n, !VEC_STB[k]);
                end
            end
            #3;
        end
        check(stb_edges == 5, "R6 five strobes in pass plus refresh", stb_edges, 5);
        check(hi_phase_low == 0, "R5 strobe high in high phase", hi_phase_low, 0);

        // ---------------- R8: overrange blanks after strobed pass ----------------
        start_meas(1'b1);
        stb_edges = 0;
        for (int j = 0; j <= 1500; j++) begin
            if (j == 0)
                check(digit_en == 5'b10000, "R8 D5 starts on overrange", digit_en, 5'b10000);
            if (j == 1000)
                check(digit_en == 5'b00001, "R8 D1 still shown", digit_en, 5'b00001);
            if (j == 1001) begin
                check(digit_en == 5'b0, "R8 lines dark", digit_en, 0);
                check(digit_idx == 3'd0, "R8 index zero when dark", digit_idx, 0);
            end
            if (j == 1500)
                check(digit_en == 5'b0, "R8 lines stay dark", digit_en, 0);
            step();
        end
        check(stb_edges == 5, "R6 five strobes with overrange", stb_edges, 5);

        // R8 recovery: next pulse without overrange scans again
        start_meas(1'b0);
        check(digit_en == 5'b10000, "R8 recovery D5", digit_en, 5'b10000);
        for (int j = 0; j < 1100; j++) step();
        check(digit_en == 5'b10000, "R7 refresh after recovery", digit_en, 5'b10000);

        // ---------------- R9: restart in the middle of a scan ----------------
        for (int j = 0; j < 300; j++) step();   // into refresh D4
        check(digit_en == 5'b01000, "R9 pre-restart D4", digit_en, 5'b01000);
        #2; #3;
        start_meas(1'b0);
        stb_edges = 0;
        for (int j = 0; j <= 1000; j++) begin
            if (j == 0)
                check(digit_en == 5'b10000, "R9 restart D5", digit_en, 5'b10000);
            if (j == 200)
                check(digit_en == 5'b10000, "R9 restart long D5", digit_en, 5'b10000);
            if (j == 201)
                check(digit_en == 5'b01000, "R9 restart D4", digit_en, 5'b01000);
            #2;
            if (j == 100)
                check(strobe_n == 1'b0, "R9 strobe re-armed", strobe_n, 0);
            #3;
        end
        check(stb_edges == 5, "R9 five strobes after restart", stb_edges, 5);

        // ---------------- R9: restart during the strobed pass ----------------
        start_meas(1'b0);
        for (int j = 0; j < 150; j++) step();
        #2; #3;
        start_meas(1'b0);
        stb_edges = 0;
        for (int j = 0; j <= 1000; j++) step();
        check(stb_edges == 5, "R9 restart within strobed D5", stb_edges, 5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule